// File: doc/BRIEF.md
# Transmit Dominant Timeout Monitor

This block sits between the transmit output of a CAN protocol controller and the enable of a bus driver. While the driver is in active mode, it measures how long the transmit input has been dominant (logic 0) since its last recessive-to-dominant edge. If that time reaches a programmable number of clock cycles, the block switches the driver off so the bus goes back to recessive. It also pulls an active-low fault line low. The fault stays set until the transmit input goes back to recessive, and then the driver is enabled again. This keeps a stuck controller or a software fault from blocking the network for every other node.

The receive path is a plain wire: the receive output mirrors the bus level at all times, including while a fault is present. The timeout is set through a parameter, in clock cycles. Its default is 60000 cycles, which is 1.2 ms at 50 MHz. That limit still admits eleven consecutive dominant bits at about 9.2 kbit/s. Leaving active mode switches the driver off and clears both the timer and the fault.

Top module: `txdom_guard`

## Requirements
- R1: While reset is asserted, and until the first clock edge after it is released internally, drv_en_o is 0, drv_data_o is 1 (recessive), and flt_n_o is 1.
- R2: In active mode with no fault, drv_en_o is 1 and drv_data_o equals the tx_data_i value sampled at the previous clock edge (0 = dominant, 1 = recessive).
- R3: Timing starts only on a recessive-to-dominant edge of tx_data_i that is seen while act_mode_i is 1. A dominant level already present when active mode is entered never causes a fault.
- R4: Count the cycle of the falling edge as cycle 1. If tx_data_i is sampled dominant for TIMEOUT_CYC consecutive cycles, the fault is set at the edge of cycle TIMEOUT_CYC. After TIMEOUT_CYC-1 such cycles, no fault is present.
- R5: While the fault is present, drv_en_o is 0, drv_data_o is 1 (recessive), and flt_n_o is 0.
- R6: The dominant-time counter saturates at TIMEOUT_CYC. The fault therefore stays set for any length of dominant hold, including holds longer than the counter's range.
- R7: A dominant-to-recessive edge of tx_data_i in active mode clears the fault and the count at that clock edge, and re-enables the driver. If the edge comes before expiry, the count restarts and no fault is raised.
- R8: rx_data_o equals bus_rx_i combinationally at all times, including during a fault.
- R9: When act_mode_i is 0 at a clock edge, the block drives drv_en_o to 0, drv_data_o to 1, and flt_n_o to 1 from that edge on, clears the count and the fault, and raises no fault however long tx_data_i stays dominant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| act_mode_i | input | 1 | 1 = driver in active mode |
| tx_data_i | input | 1 | Transmit data from the controller, 0 = dominant |
| bus_rx_i | input | 1 | Bus level from the receiver, 0 = dominant |
| drv_en_o | output | 1 | Bus driver enable |
| drv_data_o | output | 1 | Data to the bus driver, 1 (recessive) when disabled |
| rx_data_o | output | 1 | Receive data to the controller, mirrors bus_rx_i |
| flt_n_o | output | 1 | Active-low dominant-timeout fault |

## Verification
A counter that wraps, or a start that is missed or comes too early, shows as a fault edge that is missing or off by one cycle. This appears at flt_n_o and drv_en_o in the cycle the hold reaches TIMEOUT_CYC. A wrap appears only after the hold runs past the counter's range, as a driver that switches back on while the input is still dominant. A fault flag that is not cleared by the recessive edge or by leaving active mode shows in the very next cycle as a driver that stays off. The bench tests every one of these windows by counting exact cycle numbers around the expiry point, and holds the input well past the counter's range.

// File: rtl/tdg_pkg.sv
package tdg_pkg;
  localparam logic LVL_DOM = 1'b0;
  localparam logic LVL_REC = 1'b1;

  function automatic int unsigned tdg_cnt_width(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction
endpackage

// File: rtl/tdg_edge.sv
module tdg_edge
  import tdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tx_i,
  output logic fall_o,
  output logic rise_o
);
  logic tx_q, tx_d;

  always_comb begin
    tx_d = tx_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_q <= LVL_REC;
    else         tx_q <= tx_d;
  end

  assign fall_o = (tx_q == LVL_REC) && (tx_i == LVL_DOM);
  assign rise_o = (tx_q == LVL_DOM) && (tx_i == LVL_REC);
endmodule

// File: rtl/tdg_timer.sv
module tdg_timer
  import tdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 60000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic fall_i,
  input  logic rise_i,
  input  logic tx_i,
  output logic reach_o
);
  localparam int unsigned CNT_W = tdg_cnt_width(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(TIMEOUT_CYC);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             arm_q, arm_d;
  logic             cnt_en;

  always_comb begin
    cnt_d = cnt_q;
    arm_d = arm_q;
    if (!act_i || rise_i) begin
      cnt_d = '0;
      arm_d = 1'b0;
    end else if (fall_i) begin
      cnt_d = ONE;
      arm_d = 1'b1;
    end else if (arm_q && (tx_i == LVL_DOM) && (cnt_q != LIMIT)) begin
      cnt_d = cnt_q + ONE;
    end
  end

  assign cnt_en  = (cnt_d != cnt_q) || (arm_d != arm_q);
  assign reach_o = arm_d && (cnt_d >= LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      arm_q <= 1'b0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
      arm_q <= arm_d;
    end
  end

  // R6
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);

  // R3
  start_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && fall_i) |=> (cnt_q == ONE));
endmodule

// File: rtl/tdg_outstage.sv
module tdg_outstage
  import tdg_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic rise_i,
  input  logic reach_i,
  input  logic tx_i,
  output logic drv_en_o,
  output logic drv_data_o,
  output logic fault_o
);
  logic fault_q, fault_d;
  logic en_q, en_d;
  logic dat_q, dat_d;

  always_comb begin
    fault_d = fault_q;
    if (!act_i)       fault_d = 1'b0;
    else if (rise_i)  fault_d = 1'b0;
    else if (reach_i) fault_d = 1'b1;
    en_d  = act_i && !fault_d;
    dat_d = en_d ? tx_i : LVL_REC;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= 1'b0;
      en_q    <= 1'b0;
      dat_q   <= LVL_REC;
    end else begin
      fault_q <= fault_d;
      en_q    <= en_d;
      dat_q   <= dat_d;
    end
  end

  assign drv_en_o   = en_q;
  assign drv_data_o = dat_q;
  assign fault_o    = fault_q;

  // R7
  rise_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i && rise_i) |=> (!fault_q && en_q));

  // R9
  idle_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_i |=> (!fault_q && !en_q && dat_q == LVL_REC));

  // R4
  set_by_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fault_q) |-> $past(reach_i));
endmodule

// File: rtl/txdom_guard.sv
module txdom_guard
  import tdg_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 60000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_mode_i,
  input  logic tx_data_i,
  input  logic bus_rx_i,
  output logic drv_en_o,
  output logic drv_data_o,
  output logic rx_data_o,
  output logic flt_n_o
);
  logic [1:0] rst_sync_q;
  logic       rst_n;
  logic       fall, rise, reach, fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  tdg_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .tx_i   (tx_data_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  tdg_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .act_i   (act_mode_i),
    .fall_i  (fall),
    .rise_i  (rise),
    .tx_i    (tx_data_i),
    .reach_o (reach)
  );

  tdg_outstage u_out (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .act_i      (act_mode_i),
    .rise_i     (rise),
    .reach_i    (reach),
    .tx_i       (tx_data_i),
    .drv_en_o   (drv_en_o),
    .drv_data_o (drv_data_o),
    .fault_o    (fault)
  );

  assign rx_data_o = bus_rx_i;
  assign flt_n_o   = !fault;

  // R5
  fault_releases_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    !flt_n_o |-> (!drv_en_o && drv_data_o == LVL_REC));
endmodule

// File: tb/sim_txdom_guard.sv
module sim_txdom_guard;
  localparam int unsigned TO = 200;

  logic clk = 1'b0;
  logic rst_n, mode, tx, rx;
  logic en, dat, rxd, fltn;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  typedef struct {
    bit    en;
    bit    dat;
    bit    rxd;
    bit    fltn;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  txdom_guard #(.TIMEOUT_CYC(TO)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .act_mode_i(mode), .tx_data_i(tx),
    .bus_rx_i(rx), .drv_en_o(en), .drv_data_o(dat), .rx_data_o(rxd),
    .flt_n_o(fltn)
  );

  // driver: apply one cycle of inputs and push the expected outputs
  task automatic cyc(input bit m, input bit t, input bit r, input bit f, input string tag);
    exp_t e;
    @(negedge clk);
    mode = m; tx = t; rx = r;
    e.en   = m && !f;
    e.dat  = e.en ? t : 1'b1;
    e.rxd  = r;
    e.fltn = !f;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // dominant hold in active mode; fault expected from cycle 'from' (0 = never)
  task automatic dom(input int n, input int from, input string tag);
    for (int i = 1; i <= n; i++)
      cyc(1'b1, 1'b0, i[0], (from != 0) && (i >= from), tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if ({en, dat, rxd, fltn} !== {e.en, e.dat, e.rxd, e.fltn}) begin
          errors++;
          $display("FAIL %s: got en/dat/rxd/fltn=%b%b%b%b exp %b%b%b%b",
                   e.tag, en, dat, rxd, fltn, e.en, e.dat, e.rxd, e.fltn);
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; mode = 1'b1; tx = 1'b0; rx = 1'b1;
    #50;
    checks++;
    if ({en, dat, fltn} !== 3'b011) begin
      errors++;
      $display("FAIL R1 reset: got en/dat/fltn=%b%b%b exp 011", en, dat, fltn);
    end
    @(negedge clk); mode = 1'b0; tx = 1'b1; rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b1, 1'b1, 1'b0, "R1 post-reset idle");

    // R2: normal transmission passes through
    for (int i = 0; i < 6; i++) cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 idle active");
    for (int i = 0; i < 8; i++) cyc(1'b1, i[1], i[0], 1'b0, "R2 data follows");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 recessive");

    // R4: TO-1 dominant cycles give no fault, R7: release restarts count
    dom(TO - 1, 0, "R4 below limit");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R7 early release");
    dom(TO - 1, 0, "R7 count restarted");
    cyc(1'b1, 1'b1, 0, 1'b0, "R7 early release again");

    // R4/R5/R8: full timeout plus one, bus toggling while faulted
    dom(TO + 1, TO, "R4 R5 R8 expiry");
    // R6: long hold past the counter range, fault persists
    for (int i = 1; i <= 3 * TO; i++) cyc(1'b1, 1'b0, i[0], 1'b1, "R6 saturated hold");
    // R7: release clears fault and re-enables driver
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R7 release clears");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R7 re-enabled");
    dom(TO - 1, 0, "R7 fresh count after clear");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R7 release");

    // R9: inactive mode never faults
    for (int i = 0; i < TO + 10; i++) cyc(1'b0, 1'b0, i[0], 1'b0, "R9 inactive dominant");
    // R3: entering active mode with tx already dominant does not start timing
    for (int i = 0; i < TO + 10; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, "R3 no edge");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R3 release");

    // R9: leaving active mode clears a fault at once
    dom(TO + 2, TO, "R9 fault before exit");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, "R9 exit clears fault");
    cyc(1'b0, 1'b0, 1'b0, 1'b0, "R9 stays clear");
    // R3: re-entry while still dominant: no new start
    for (int i = 0; i < TO + 3; i++) cyc(1'b1, 1'b0, 1'b1, 1'b0, "R3 re-entry held");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R3 release after re-entry");

    // R7: repeated near-limit pulses never fault
    for (int k = 0; k < 3; k++) begin
      dom(TO - 1, 0, "R7 pulse train");
      cyc(1'b1, 1'b1, 1'b1, 1'b0, "R7 pulse gap");
    end
    // R4: exact limit sets fault on cycle TO
    dom(TO, TO, "R4 exact limit");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, "R7 final release");
    cyc(1'b1, 1'b1, 1'b1, 1'b0, "R2 final idle");

    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule